// File: doc/BRIEF.md
# Multi-cycle integer divider with selectable rounding

This block divides a dividend by a divisor over several clock cycles and returns the quotient. Each operand has its own flag that marks it as two's-complement signed. The division is signed only when both flags are set; if either operand is unsigned, both are treated as unsigned. A mode input picks how the quotient is rounded: toward zero (truncate) or toward negative infinity (floor).

Floor mode is built on the same truncating core. The numerator is widened and adjusted before the magnitude division. When the operand signs differ and the dividend is nonzero, the divisor is moved one step toward zero and then subtracted from the dividend. The core is a restoring shift-subtract loop that produces one quotient bit per clock.

A request is accepted on a clock edge where `start_i` is high and `busy_o` is low. The result appears with a one-cycle `done_o` pulse. A zero divisor skips the loop and is reported with `div_zero_o`.

Top module: `sdiv_round`

## Requirements
- R1: With `floor_i`=0 and both `a_signed_i` and `b_signed_i` set to 1, `quot_o` is the exact quotient of the two's-complement operands rounded toward zero.
- R2: With `floor_i`=1 and both operands signed, `quot_o` is the exact quotient rounded toward negative infinity. It is one below the truncated value when the signs differ and the division leaves a remainder.
- R3: If either signed flag is 0, both operands are read as unsigned binary, and `floor_i` has no effect on `quot_o`.
- R4: `quot_o` carries the low Q_W bits of the two's-complement quotient, so a result that does not fit wraps. For example, with 4-bit operands, -8 / -1 gives 4'b1000.
- R5: A zero divisor at acceptance raises `done_o` and `div_zero_o` together in the cycle right after the accepting edge, with `quot_o` all ones. A nonzero divisor never raises `div_zero_o`.
- R6: For a nonzero divisor, `busy_o` goes high after the accepting edge, and `done_o` is raised by the edge exactly W edges after it, where W = max(A_W, B_W, Q_W) + 1. `busy_o` falls at that same edge. `done_o` is never high while `busy_o` is high.
- R7: A high `start_i` while `busy_o` is high is ignored. Latency and result are those of the request already running.
- R8: `done_o` stays high for a single cycle unless a new request is accepted. `quot_o` holds its value until the next request is accepted.
- R9: After reset, `busy_o`, `done_o` and `div_zero_o` are low and `quot_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division (taken when not busy) |
| a_i | input | A_W | Dividend |
| b_i | input | B_W | Divisor |
| a_signed_i | input | 1 | 1: dividend is two's complement |
| b_signed_i | input | 1 | 1: divisor is two's complement |
| floor_i | input | 1 | 1: round toward negative infinity, 0: toward zero |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| div_zero_o | output | 1 | Divisor was zero (with `done_o`) |
| quot_o | output | Q_W | Quotient |

## Verification
The hardest cases to reach are signed floor divisions whose signs differ and whose dividend is at or near the most negative value. There the adjusted numerator uses the full extra bit, and quotients such as -8 / -1 wrap. The bench reaches them by sweeping every 4-bit dividend and divisor under all four signedness combinations and both rounding modes. It also issues extra requests that hold `start_i` high with different operands for the whole busy window. This shows the running division is neither restarted nor corrupted.

// File: rtl/div_round_pkg.sv
package div_round_pkg;
  function automatic int max3(input int x, input int y, input int z);
    int m;
    m = (x > y) ? x : y;
    return (m > z) ? m : z;
  endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_round_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 16,
  parameter int W   = 17
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           a_signed_i,
  input  logic           b_signed_i,
  input  logic           floor_i,
  output logic [W-1:0]   num_mag_o,
  output logic [W-1:0]   den_mag_o,
  output logic           neg_o,
  output logic           den_zero_o
);
  logic         sgn, a_neg, b_neg, adjust;
  logic [W-1:0] a_ext, b_ext, b_step, num;

  always_comb begin
    sgn    = a_signed_i & b_signed_i;
    a_neg  = sgn & a_i[A_W-1];
    b_neg  = sgn & b_i[B_W-1];
    a_ext  = {{(W-A_W){a_neg}}, a_i};
    b_ext  = {{(W-B_W){b_neg}}, b_i};
    // divisor moved one step toward zero, then subtracted (floor correction)
    b_step = b_neg ? b_ext + W'(1) : b_ext - W'(1);
    adjust = floor_i & sgn & (a_neg ^ b_neg) & (a_i != '0);
    num    = adjust ? a_ext - b_step : a_ext;
    num_mag_o  = num[W-1] ? -num : num;
    den_mag_o  = b_neg ? -b_ext : b_ext;
    neg_o      = num[W-1] ^ b_neg;
    den_zero_o = (b_i == '0);
  end
endmodule

// File: rtl/div_shift_core.sv
module div_shift_core
  import div_round_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] q_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, dvd_q, den_q, q_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q;
  logic [W:0]    shifted, diff;
  logic          take;

  always_comb begin
    shifted = {rem_q, dvd_q[W-1]};
    diff    = shifted - {1'b0, den_q};
    take    = ~diff[W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (load_i) begin
      rem_q  <= '0;
      dvd_q  <= num_i;
      den_q  <= den_i;
      q_q    <= '0;
      cnt_q  <= CW'(W - 1);
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
    end else if (busy_q) begin
      rem_q <= take ? diff[W-1:0] : shifted[W-1:0];
      dvd_q <= {dvd_q[W-2:0], 1'b0};
      q_q   <= {q_q[W-2:0], take};
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = fin_q;
  assign q_o    = q_q;
endmodule

// File: rtl/sdiv_round.sv
module sdiv_round
  import div_round_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 16,
  parameter int Q_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           a_signed_i,
  input  logic           b_signed_i,
  input  logic           floor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           div_zero_o,
  output logic [Q_W-1:0] quot_o
);
  localparam int W = max3(A_W, B_W, Q_W) + 1;

  logic [W-1:0] num_mag, den_mag, core_q, q_fix;
  logic         neg, den_zero, accept, core_busy, core_fin;
  logic         neg_q, zero_q, zero_done_q;

  div_operand_prep #(.A_W(A_W), .B_W(B_W), .W(W)) i_prep (
    .a_i        (a_i),
    .b_i        (b_i),
    .a_signed_i (a_signed_i),
    .b_signed_i (b_signed_i),
    .floor_i    (floor_i),
    .num_mag_o  (num_mag),
    .den_mag_o  (den_mag),
    .neg_o      (neg),
    .den_zero_o (den_zero)
  );

  assign accept = start_i & ~core_busy;

  div_shift_core #(.W(W)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept & ~den_zero),
    .num_i  (num_mag),
    .den_i  (den_mag),
    .busy_o (core_busy),
    .fin_o  (core_fin),
    .q_o    (core_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q       <= 1'b0;
      zero_q      <= 1'b0;
      zero_done_q <= 1'b0;
    end else begin
      zero_done_q <= accept & den_zero;
      if (accept) begin
        neg_q  <= neg;
        zero_q <= den_zero;
      end
    end
  end

  assign q_fix      = neg_q ? -core_q : core_q;
  assign quot_o     = zero_q ? '1 : q_fix[Q_W-1:0];
  assign busy_o     = core_busy;
  assign done_o     = core_fin | zero_done_q;
  assign div_zero_o = zero_done_q;
endmodule

// File: rtl/sdiv_round_chk.sv
module sdiv_round_chk
  import div_round_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 16,
  parameter int Q_W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [B_W-1:0] b_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           div_zero_o,
  input logic [Q_W-1:0] quot_o
);
  localparam int W  = max3(A_W, B_W, Q_W) + 1;
  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (start_i && !busy_o && b_i != '0) lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + CW'(1);
  end

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> done_o && quot_o == '1); // R5
  AST_ZERO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && b_i == '0 |=> div_zero_o && !busy_o); // R5
  AST_NZ_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && b_i != '0 |=> busy_o && !div_zero_o); // R6
  AST_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R6
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o && lat_q == CW'(W)); // R6
  AST_BUSY_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o); // R8
  AST_QUOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(quot_o)); // R8
endmodule

bind sdiv_round sdiv_round_chk #(.A_W(A_W), .B_W(B_W), .Q_W(Q_W)) i_sdiv_round_chk (
  .clk_i, .rst_ni, .start_i, .b_i, .busy_o, .done_o, .div_zero_o, .quot_o
);

// File: tb/test_sdiv_round.sv
`timescale 1ns/1ps
module test_sdiv_round;
  localparam int AW = 4;
  localparam int W  = AW + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] a_i = '0, b_i = '0;
  logic          a_signed_i = 1'b0, b_signed_i = 1'b0, floor_i = 1'b0;
  logic          busy_o, done_o, div_zero_o;
  logic [AW-1:0] quot_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  sdiv_round #(.A_W(AW), .B_W(AW), .Q_W(AW)) i_sdiv_round (
    .clk_i, .rst_ni, .start_i, .a_i, .b_i, .a_signed_i, .b_signed_i,
    .floor_i, .busy_o, .done_o, .div_zero_o, .quot_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_quot(input logic [AW-1:0] a, b,
                                             input logic as, bs, fl);
    int av, bv, q;
    bit sgn;
    sgn = as & bs;
    av = sgn ? int'($signed(a)) : int'(a);
    bv = sgn ? int'($signed(b)) : int'(b);
    if (bv == 0) return '1;
    q = av / bv;
    if (fl && sgn && (av % bv) != 0 && ((av < 0) != (bv < 0))) q = q - 1;
    return AW'(q);
  endfunction

  task automatic run_op(input logic [AW-1:0] a, b, input logic as, bs, fl,
                        input bit junk);
    int lat;
    string tag;
    logic [AW-1:0] exp, held;
    if (junk) tag = "R7";
    else if (b == '0) tag = "R5";
    else if (!(as && bs)) tag = "R3";
    else if (a == 4'h8 && b == 4'hF) tag = "R4";
    else tag = fl ? "R2" : "R1";
    exp = exp_quot(a, b, as, bs, fl);
    @(negedge clk_i);
    a_i = a; b_i = b; a_signed_i = as; b_signed_i = bs; floor_i = fl;
    start_i = 1'b1;
    @(negedge clk_i);
    lat = 0;
    if (junk) begin
      a_i = ~a; b_i = b + 4'd3; floor_i = ~fl; a_signed_i = ~as;
    end else begin
      start_i = 1'b0;
    end
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    chk(lat == ((b == '0) ? 0 : W), (b == '0) ? "R5" : "R6", "latency", lat,
        (b == '0) ? 0 : W);
    chk(quot_o == exp, tag, "quotient", quot_o, exp);
    chk(div_zero_o == (b == '0), "R5", "div_zero", div_zero_o, (b == '0));
    held = quot_o;
    @(negedge clk_i);
    chk(!done_o, "R8", "done width", done_o, 0);
    chk(quot_o == held, "R8", "quotient hold", quot_o, held);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!busy_o, "R9", "busy", busy_o, 0);
    chk(!done_o, "R9", "done", done_o, 0);
    chk(!div_zero_o, "R9", "div_zero", div_zero_o, 0);
    chk(quot_o == '0, "R9", "quotient", quot_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // exhaustive sweep: R1 R2 R3 R4 R5 R6 R8
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 2; f++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run_op(AW'(a), AW'(b), s[0], s[1], f[0], 1'b0);

    // R7: start held with other operands throughout busy
    run_op(4'h9, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1);
    run_op(4'h7, 4'hE, 1'b1, 1'b1, 1'b0, 1'b1);
    run_op(4'hF, 4'h3, 1'b0, 1'b0, 1'b1, 1'b1);
    run_op(4'h8, 4'h1, 1'b1, 1'b1, 1'b1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule